// File: doc/BRIEF.md
# Stuff Command Majority Decoder

This block decides once per minor frame whether a received stuff command code asks for a positive stuff, a negative stuff, or no action. The receive path presents the serial stuff-code bits one at a time together with a strobe. Two saturating tallies count how many received bits disagree with the positive reference code and how many disagree with the negative reference code. A code is therefore recognised even when some of its bits arrive corrupted.

A word strobe advances a word-slot index that starts from zero at each frame start. While the index equals the decision slot (28 by default), the decoder compares each tally with a threshold of eight. It then raises at most one of two flags. Outside that slot both flags stay low. Both flags low inside the slot means no action. The data path that carries out the stuff is outside this block.

Top module: `stuff_cmd_decoder`

## Requirements
- R1: On each code-bit strobe, the received bit is compared with bit k of the positive reference code (default 21'h0F3A5C) and with bit k of the negative reference code (default, its bitwise complement). Here k is the number of strobes accepted since the frame started, and bit 0 comes first. Each tally whose reference bit differs from the received bit increments by one.
- R2: Each tally saturates at 15 and never wraps.
- R3: A frame_start pulse clears both tallies, the bit position and the word-slot index to zero. Code-bit strobes and word strobes that arrive in the same cycle as frame_start are discarded.
- R4: Each word strobe advances the word-slot index by one. Both flags are low whenever the index is not 28, so the decision slot begins after the 28th word strobe that follows the frame start.
- R5: In slot 28, pos_stuff is high when the positive tally is below 8 and either the negative tally is 8 or more or the positive tally is strictly lower than the negative tally.
- R6: In slot 28, neg_stuff is high when the negative tally is below 8 and either the positive tally is 8 or more or the negative tally is strictly lower than the positive tally.
- R7: When both tallies are 8 or more, both flags are low in slot 28, which means no action.
- R8: When both tallies are below 8 and equal, both flags are low in slot 28.
- R9: Code-bit strobes after the 21st accepted bit of a frame do not change either tally.
- R10: After reset, both flags are low, both tallies and both indices are zero, and a frame may be decoded without a leading frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Minor-frame start pulse |
| code_strobe | input | 1 | Qualifies code_bit as the next stuff-code bit |
| code_bit | input | 1 | Serial received data bit |
| word_strobe | input | 1 | Advances the word-slot index |
| pos_stuff | output | 1 | Positive stuff decided (slot 28 only) |
| neg_stuff | output | 1 | Negative stuff decided (slot 28 only) |

## Verification
The bench sends error-free positive and negative codes, and codes with 7, 8, 13 and 14 corrupted bits. These sit on either side of the threshold and separate "below eight" from "eight or more" for each tally. Short frames with equal and with unequal tallies, both under eight, separate the tie rule from the lower-count rule. A frame with 17 errors against the positive code gives a different verdict with a wrapping counter than with a saturating one. Trailing extra bits show whether strobes past the code length are ignored. A frame start that collides with a corrupting bit strobe and a word strobe shows whether those strobes are discarded. Each frame is also checked in slots 27 and 29 to confirm that the flags are confined to slot 28.

// File: rtl/stuff_pkg.sv
package stuff_pkg;
   typedef enum logic [1:0] {
      VERDICT_NONE = 2'd0,
      VERDICT_POS  = 2'd1,
      VERDICT_NEG  = 2'd2
   } verdict_e;

   localparam int unsigned NUM_REFS = 2;
   localparam int unsigned REF_POS  = 0;
   localparam int unsigned REF_NEG  = 1;
endpackage

// File: rtl/stuff_seq_tracker.sv
module stuff_seq_tracker #(
   parameter int unsigned CODE_LEN = 21,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned WORD_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              code_strobe,
   input  logic              word_strobe,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              bit_take,
   output logic [WORD_W-1:0] word_idx
);
   localparam logic [IDX_W-1:0]  LAST_BIT = IDX_W'(CODE_LEN);
   localparam logic [WORD_W-1:0] WORD_MAX = '1;

   assign bit_take = code_strobe && !frame_start && (bit_idx < LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx  <= '0;
         word_idx <= '0;
      end else if (frame_start) begin
         bit_idx  <= '0;
         word_idx <= '0;
      end else begin
         if (bit_take) bit_idx <= bit_idx + 1'b1;
         if (word_strobe && word_idx != WORD_MAX) word_idx <= word_idx + 1'b1;
      end
   end
endmodule

// File: rtl/stuff_err_tally.sv
module stuff_err_tally #(
   parameter int unsigned CODE_LEN = 21,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned CNT_W    = 4,
   parameter logic [CODE_LEN-1:0] REF_CODE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             code_bit,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned EXT_LEN = 1 << IDX_W;
   localparam logic [EXT_LEN-1:0] REF_EXT = EXT_LEN'(REF_CODE);
   localparam logic [CNT_W-1:0]   CNT_MAX = '1;

   logic mismatch;
   assign mismatch = REF_EXT[bit_idx] ^ code_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  count <= '0;
      else if (clear)                              count <= '0;
      else if (take && mismatch && count != CNT_MAX) count <= count + 1'b1;
   end
endmodule

// File: rtl/stuff_verdict.sv
module stuff_verdict
   import stuff_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned WORD_W = 6,
   parameter int unsigned THRESH = 8,
   parameter int unsigned SLOT   = 28
) (
   input  logic [CNT_W-1:0]  pos_cnt,
   input  logic [CNT_W-1:0]  neg_cnt,
   input  logic [WORD_W-1:0] word_idx,
   output logic              pos_stuff,
   output logic              neg_stuff
);
   localparam logic [CNT_W-1:0]  THR = CNT_W'(THRESH);
   localparam logic [WORD_W-1:0] SLT = WORD_W'(SLOT);

   verdict_e verdict;
   logic pos_ok, neg_ok;

   always_comb begin
      pos_ok  = pos_cnt < THR;
      neg_ok  = neg_cnt < THR;
      verdict = VERDICT_NONE;
      if (word_idx == SLT) begin
         if (pos_ok && (!neg_ok || pos_cnt < neg_cnt))      verdict = VERDICT_POS;
         else if (neg_ok && (!pos_ok || neg_cnt < pos_cnt)) verdict = VERDICT_NEG;
      end
   end

   assign pos_stuff = (verdict == VERDICT_POS);
   assign neg_stuff = (verdict == VERDICT_NEG);
endmodule

// File: rtl/stuff_cmd_decoder.sv
module stuff_cmd_decoder
   import stuff_pkg::*;
#(
   parameter int unsigned CODE_LEN = 21,
   parameter logic [CODE_LEN-1:0] POS_CODE = 21'h0F3A5C,
   parameter logic [CODE_LEN-1:0] NEG_CODE = ~POS_CODE,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned THRESH   = 8,
   parameter int unsigned WORD_W   = 6,
   parameter int unsigned SLOT     = 28
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic code_strobe,
   input  logic code_bit,
   input  logic word_strobe,
   output logic pos_stuff,
   output logic neg_stuff
);
   localparam int unsigned IDX_W = $clog2(CODE_LEN + 1);

   if (CODE_LEN < 1) begin : g_bad_len
      $error("CODE_LEN must be at least 1");
   end
   if (THRESH < 1 || THRESH > (1 << CNT_W) - 1) begin : g_bad_thr
      $error("THRESH must fit below the tally saturation value");
   end
   if (SLOT > (1 << WORD_W) - 2) begin : g_bad_slot
      $error("SLOT must be representable below the word index limit");
   end

   logic [IDX_W-1:0]  bit_idx;
   logic              bit_take;
   logic [WORD_W-1:0] word_idx;
   logic [CNT_W-1:0]  err_cnt [NUM_REFS];

   stuff_seq_tracker #(
      .CODE_LEN(CODE_LEN), .IDX_W(IDX_W), .WORD_W(WORD_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .code_strobe(code_strobe), .word_strobe(word_strobe),
      .bit_idx(bit_idx), .bit_take(bit_take), .word_idx(word_idx)
   );

   for (genvar r = 0; r < NUM_REFS; r++) begin : g_tally
      localparam logic [CODE_LEN-1:0] REF = (r == REF_POS) ? POS_CODE : NEG_CODE;
      stuff_err_tally #(
         .CODE_LEN(CODE_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W), .REF_CODE(REF)
      ) u_tally (
         .clk(clk), .rst_n(rst_n), .clear(frame_start), .take(bit_take),
         .bit_idx(bit_idx), .code_bit(code_bit), .count(err_cnt[r])
      );
   end

   stuff_verdict #(
      .CNT_W(CNT_W), .WORD_W(WORD_W), .THRESH(THRESH), .SLOT(SLOT)
   ) u_verdict (
      .pos_cnt(err_cnt[REF_POS]), .neg_cnt(err_cnt[REF_NEG]),
      .word_idx(word_idx), .pos_stuff(pos_stuff), .neg_stuff(neg_stuff)
   );
endmodule

// File: rtl/stuff_cmd_decoder_chk.sv
module stuff_cmd_decoder_chk #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned THRESH = 8,
   parameter int unsigned WORD_W = 6,
   parameter int unsigned SLOT   = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             word_strobe,
   input logic             pos_stuff,
   input logic             neg_stuff,
   input logic [CNT_W-1:0] pos_cnt,
   input logic [CNT_W-1:0] neg_cnt
);
   localparam logic [CNT_W-1:0]  CMAX = '1;
   localparam logic [CNT_W-1:0]  THR  = CNT_W'(THRESH);
   localparam logic [WORD_W-1:0] WMAX = '1;
   localparam logic [WORD_W-1:0] SLT  = WORD_W'(SLOT);

   logic [WORD_W-1:0] chk_word;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          chk_word <= '0;
      else if (frame_start)                chk_word <= '0;
      else if (word_strobe && chk_word != WMAX) chk_word <= chk_word + 1'b1;
   end

   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pos_stuff && neg_stuff));
   assert_slot_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_word != SLT) |-> (!pos_stuff && !neg_stuff));
   assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_cnt == CMAX && !frame_start) |=> (pos_cnt == CMAX));
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (pos_cnt == '0 && neg_cnt == '0));
   assert_no_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_cnt >= THR && neg_cnt >= THR) |-> (!pos_stuff && !neg_stuff));
   assert_pos_thresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pos_stuff |-> (pos_cnt < THR));
   assert_neg_thresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
      neg_stuff |-> (neg_cnt < THR));
endmodule

bind stuff_cmd_decoder stuff_cmd_decoder_chk #(
   .CNT_W(CNT_W), .THRESH(THRESH), .WORD_W(WORD_W), .SLOT(SLOT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .word_strobe(word_strobe),
   .pos_stuff(pos_stuff), .neg_stuff(neg_stuff),
   .pos_cnt(err_cnt[0]), .neg_cnt(err_cnt[1])
);

// File: tb/test_stuff_cmd_decoder.sv
module test_stuff_cmd_decoder;
   localparam int CLEN = 21;
   localparam logic [CLEN-1:0] POS = 21'h0F3A5C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, code_strobe = 1'b0, code_bit = 1'b0, word_strobe = 1'b0;
   logic pos_stuff, neg_stuff;

   int total = 0, fails = 0;
   bit done = 0;
   bit probe = 0;
   logic [1:0] exp_q [$];
   string      tag_q [$];

   always #10ns clk = ~clk;

   stuff_cmd_decoder i_stuff_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .code_strobe(code_strobe),
      .code_bit(code_bit), .word_strobe(word_strobe),
      .pos_stuff(pos_stuff), .neg_stuff(neg_stuff)
   );

   task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: {pos,neg} actual %b expected %b", req, act, exp);
      end
   endtask

   // Monitor: pops the expected verdict when the driver reaches the decision slot
   initial forever begin
      @(posedge clk);
      #5ns;
      if (probe) begin
         logic [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({pos_stuff, neg_stuff} == e, t, {pos_stuff, neg_stuff}, e);
         probe = 0;
      end
   end

   task automatic send_bit(input logic b);
      @(negedge clk); code_strobe = 1'b1; code_bit = b;
      @(negedge clk); code_strobe = 1'b0;
   endtask

   task automatic step_word();
      @(negedge clk); word_strobe = 1'b1;
      @(negedge clk); word_strobe = 1'b0;
   endtask

   // nbits strobes; bit i carries POS[i] xor flip[i] (bits past CLEN carry flip[i])
   task automatic run_frame(input bit use_start, input bit collide, input int nbits,
                            input logic [63:0] flip, input string req);
      int p = 0, q = 0;
      logic [1:0] e;
      if (collide) begin
         // R3: strobes in the frame_start cycle must be discarded
         @(negedge clk); frame_start = 1'b1; code_strobe = 1'b1; word_strobe = 1'b1;
         code_bit = ~POS[0];
         @(negedge clk); frame_start = 1'b0; code_strobe = 1'b0; word_strobe = 1'b0;
      end else if (use_start) begin
         @(negedge clk); frame_start = 1'b1;
         @(negedge clk); frame_start = 1'b0;
      end
      for (int i = 0; i < nbits; i++) begin
         send_bit(i < CLEN ? (POS[i] ^ flip[i]) : flip[i]);
         if (i < CLEN) begin
            if (flip[i]) p++; else q++;
         end
      end
      if (p > 15) p = 15;
      if (q > 15) q = 15;
      e = 2'b00;
      if (p < 8 && (q >= 8 || p < q))      e = 2'b10;
      else if (q < 8 && (p >= 8 || q < p)) e = 2'b01;
      for (int w = 1; w <= 27; w++) step_word();
      check({pos_stuff, neg_stuff} == 2'b00, {req, " R4 slot27"}, {pos_stuff, neg_stuff}, 2'b00);
      exp_q.push_back(e);
      tag_q.push_back(req);
      step_word();
      probe = 1;
      wait (probe == 0);
      step_word();
      check({pos_stuff, neg_stuff} == 2'b00, {req, " R4 slot29"}, {pos_stuff, neg_stuff}, 2'b00);
   endtask

   initial begin
      #4ms;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({pos_stuff, neg_stuff} == 2'b00, "R10 reset", {pos_stuff, neg_stuff}, 2'b00);
      rst_n = 1'b1;
      run_frame(0, 0, 21, 64'h0,           "R10 R1 R5 exact positive after reset");
      run_frame(1, 0, 21, 64'h1FFFFF,      "R1 R6 exact negative");
      run_frame(1, 0, 21, 64'h7F,          "R5 seven errors");
      run_frame(1, 0, 21, 64'hFF,          "R7 eight errors");
      run_frame(1, 0, 21, 64'h1FFF,        "R7 thirteen errors");
      run_frame(1, 0, 21, 64'h3FFF,        "R6 fourteen errors");
      run_frame(1, 0, 10, 64'h1F,          "R8 tie five");
      run_frame(1, 0, 14, 64'h7F,          "R8 tie seven");
      run_frame(1, 0, 10, 64'h7,           "R5 lower count three vs seven");
      run_frame(1, 0, 10, 64'h7F,          "R6 lower count three vs seven");
      run_frame(1, 0, 21, 64'h1FFFF,       "R2 saturation seventeen errors");
      run_frame(1, 0, 31, 64'h7FE00000,    "R9 extra bits ignored");
      run_frame(0, 1, 21, 64'h7F,          "R3 collision discarded");
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule